// File: doc/BRIEF.md
# Tagged Result Bus Arbiter

This block decides, slot by slot, which of eleven result producers may drive a single shared result bus, and it announces the winner to every listener. The producers fall into three groups: six operand fetch buffers, two multiply/divide stations and three add stations. Each one has a fixed 4-bit identity tag. A producer raises its request two cycles before its result will be ready. The arbiter registers the request, resolves priority in the next cycle and, in the slot after that, raises the winner's select. In that same cycle it puts the winner's tag, a valid strobe and the winner's data on the bus.

Listeners never see a one-hot grant. They see a numeric tag and compare it against the tags they are waiting on. Tag 0 means that nobody is driving. A producer keeps its request high until one cycle after its select. The arbiter therefore keeps track of the two most recent winners, so that a served request that is still visible through the request register is not granted a second time.

Top module: `rbus_arbiter`

## Requirements
- R1: Producer tags are fixed. Fetch buffer i (i = 0..5, bit i of the fetch vectors) has tag i+1. Multiply/divide station j (j = 0..1) has tag 8+j. Add station k (k = 0..2) has tag 10+k. Tags 0, 7 and 13..15 are never driven.
- R2: A request that is alone and first seen high in cycle n gives a bus slot in cycle n+2. In that slot the producer's select is high, the broadcast tag equals the producer's tag and the bus data equals that producer's data input.
- R3: When several requests are eligible for the same slot, the one with the highest tag wins.
- R4: A request that loses stays queued and wins a later slot. While any eligible request is waiting, no slot is left empty, so a group of N requests raised together fills N consecutive slots.
- R5: A producer that lowers its request one cycle after its select gets exactly one slot per request.
- R6: When no producer is granted, valid is 0, the tag is 0, the bus data is 0 and all selects are low. Valid is 1 exactly when the tag is nonzero.
- R7: At most one select is high in any cycle, and it belongs to the producer whose tag is broadcast.
- R8: Reset empties the pipeline. A request captured before reset never reaches the bus, and all outputs stay idle during reset.
- R9: A higher-tag request that arrives after lower-tag requests overtakes them in the first slot it can reach. The displaced requests follow in priority order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetchReq | input | 6 | Bus requests from fetch buffers (tags 1..6) |
| mulReq | input | 2 | Bus requests from multiply/divide stations (tags 8..9) |
| addReq | input | 3 | Bus requests from add stations (tags 10..12) |
| fetchData | input | 96 | Fetch buffer results, 16 bits each, buffer i at bits [16i+15:16i] |
| mulData | input | 32 | Multiply/divide results, 16 bits each |
| addData | input | 48 | Add station results, 16 bits each |
| fetchSel | output | 6 | Drive strobe to each fetch buffer |
| mulSel | output | 2 | Drive strobe to each multiply/divide station |
| addSel | output | 3 | Drive strobe to each add station |
| busValid | output | 1 | A producer is driving the bus this cycle |
| busTag | output | 4 | Tag of the driving producer, 0 when idle |
| busData | output | 16 | Data of the driving producer, 0 when idle |

## Verification
Two things can meet in one priority decision. The first is a served producer's request that is still high during its hold-over cycle. The second is a fresh request with a higher tag that arrives while lower tags are still queued. The bench provokes both at once: it raises tags 3 and 2 together and then raises tag 12 one cycle later. It expects the slot order 3, 12, 2, followed by idle slots. Any repeat of 3 or 12, or any empty slot before 2 is served, shows that the hold-over masking and the priority scan are interacting wrongly.

// File: rtl/rbus_pkg.sv
package rbus_pkg;
  localparam int RBUS_TAG_W = 4;

  // control-to-datapath strobe bundle: one slot decision
  typedef struct packed {
    logic                  valid;
    logic [RBUS_TAG_W-1:0] tag;
  } slot_t;
endpackage

// File: rtl/rbus_arb_ctrl.sv
module rbus_arb_ctrl
  import rbus_pkg::*;
#(
  parameter int NUM_TAGS = 1 << RBUS_TAG_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_TAGS-1:0] reqByTag,
  output slot_t               slotOut
);
  logic [NUM_TAGS-1:0] reqQ;
  logic [NUM_TAGS-1:0] inFlight;
  logic [NUM_TAGS-1:0] eligible;
  slot_t slotQ, prevQ, pick;

  // first lead cycle: request propagation register
  // second lead cycle: priority result register
  always_ff @(posedge clk) begin
    if (rst) begin
      reqQ  <= '0;
      slotQ <= '0;
      prevQ <= '0;
    end else begin
      reqQ  <= reqByTag;
      slotQ <= pick;
      prevQ <= slotQ;
    end
  end

  // producers hold their request one cycle past select: mask the last two winners
  always_comb begin
    inFlight = '0;
    if (slotQ.valid) inFlight[slotQ.tag] = 1'b1;
    if (prevQ.valid) inFlight[prevQ.tag] = 1'b1;
    eligible    = reqQ & ~inFlight;
    eligible[0] = 1'b0;
  end

  // fixed priority, highest tag first
  always_comb begin
    pick = '0;
    for (int t = NUM_TAGS - 1; t >= 0; t--) begin
      if (!pick.valid && eligible[t]) begin
        pick.valid = 1'b1;
        pick.tag   = RBUS_TAG_W'(t);
      end
    end
  end

  assign slotOut = slotQ;

  // R6
  valid_tag_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    slotQ.valid |-> slotQ.tag != '0);
  // R6
  idle_tag_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !slotQ.valid |-> slotQ.tag == '0);
  // R2
  lead_backed_chk: assert property (@(posedge clk) disable iff (rst)
    slotQ.valid |-> (($past(reqByTag, 2) >> slotQ.tag) & NUM_TAGS'(1)) != '0);
  // R5
  no_repeat_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (slotQ.valid && $past(slotQ.valid)) |-> slotQ.tag != $past(slotQ.tag));
endmodule

// File: rtl/rbus_arb_datapath.sv
module rbus_arb_datapath
  import rbus_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_TAGS = 1 << RBUS_TAG_W
) (
  input  slot_t                  slotIn,
  input  logic [DATA_W-1:0]      dataByTag [NUM_TAGS],
  output logic                   busValid,
  output logic [RBUS_TAG_W-1:0]  busTag,
  output logic [DATA_W-1:0]      busData
);
  always_comb begin
    busValid = slotIn.valid;
    busTag   = slotIn.valid ? slotIn.tag : '0;
    busData  = slotIn.valid ? dataByTag[slotIn.tag] : '0;
  end
endmodule

// File: rtl/rbus_arbiter.sv
module rbus_arbiter
  import rbus_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int NUM_FETCH  = 6,
  parameter int NUM_MUL    = 2,
  parameter int NUM_ADD    = 3,
  parameter int FETCH_BASE = 1,
  parameter int MUL_BASE   = 8,
  parameter int ADD_BASE   = 10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_FETCH-1:0]        fetchReq,
  input  logic [NUM_MUL-1:0]          mulReq,
  input  logic [NUM_ADD-1:0]          addReq,
  input  logic [NUM_FETCH*DATA_W-1:0] fetchData,
  input  logic [NUM_MUL*DATA_W-1:0]   mulData,
  input  logic [NUM_ADD*DATA_W-1:0]   addData,
  output logic [NUM_FETCH-1:0]        fetchSel,
  output logic [NUM_MUL-1:0]          mulSel,
  output logic [NUM_ADD-1:0]          addSel,
  output logic                        busValid,
  output logic [RBUS_TAG_W-1:0]       busTag,
  output logic [DATA_W-1:0]           busData
);
  localparam int TAG_W    = RBUS_TAG_W;
  localparam int NUM_TAGS = 1 << TAG_W;

  logic [NUM_TAGS-1:0] reqByTag;
  logic [DATA_W-1:0]   dataByTag [NUM_TAGS];
  slot_t               slot;

  // R1: fold the three producer groups onto the tag space
  always_comb begin
    reqByTag = '0;
    for (int t = 0; t < NUM_TAGS; t++) dataByTag[t] = '0;
    for (int i = 0; i < NUM_FETCH; i++) begin
      reqByTag[FETCH_BASE+i]  = fetchReq[i];
      dataByTag[FETCH_BASE+i] = fetchData[i*DATA_W +: DATA_W];
    end
    for (int j = 0; j < NUM_MUL; j++) begin
      reqByTag[MUL_BASE+j]  = mulReq[j];
      dataByTag[MUL_BASE+j] = mulData[j*DATA_W +: DATA_W];
    end
    for (int k = 0; k < NUM_ADD; k++) begin
      reqByTag[ADD_BASE+k]  = addReq[k];
      dataByTag[ADD_BASE+k] = addData[k*DATA_W +: DATA_W];
    end
  end

  rbus_arb_ctrl #(.NUM_TAGS(NUM_TAGS)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .reqByTag (reqByTag),
    .slotOut  (slot)
  );

  rbus_arb_datapath #(.DATA_W(DATA_W), .NUM_TAGS(NUM_TAGS)) dp_i (
    .slotIn    (slot),
    .dataByTag (dataByTag),
    .busValid  (busValid),
    .busTag    (busTag),
    .busData   (busData)
  );

  // select return: decoded from the broadcast tag
  for (genvar i = 0; i < NUM_FETCH; i++) begin : g_fetchSel
    assign fetchSel[i] = busValid && (busTag == TAG_W'(FETCH_BASE + i));
  end
  for (genvar j = 0; j < NUM_MUL; j++) begin : g_mulSel
    assign mulSel[j] = busValid && (busTag == TAG_W'(MUL_BASE + j));
  end
  for (genvar k = 0; k < NUM_ADD; k++) begin : g_addSel
    assign addSel[k] = busValid && (busTag == TAG_W'(ADD_BASE + k));
  end

  // R7
  one_select_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({addSel, mulSel, fetchSel}));
  // R7
  select_when_valid_chk: assert property (@(posedge clk) disable iff (rst)
    busValid |-> $countones({addSel, mulSel, fetchSel}) == 1);
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busValid |-> (busData == '0 && {addSel, mulSel, fetchSel} == '0));
endmodule

// File: tb/rbus_arbiter_tb.sv
module rbus_arbiter_tb_top;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] fetchReq = '0;
  logic [1:0] mulReq = '0;
  logic [2:0] addReq = '0;
  logic [6*DW-1:0] fetchData;
  logic [2*DW-1:0] mulData;
  logic [3*DW-1:0] addData;
  logic [5:0] fetchSel;
  logic [1:0] mulSel;
  logic [2:0] addSel;
  logic busValid;
  logic [3:0] busTag;
  logic [DW-1:0] busData;

  rbus_arbiter dut_i (
    .clk(clk), .rst(rst),
    .fetchReq(fetchReq), .mulReq(mulReq), .addReq(addReq),
    .fetchData(fetchData), .mulData(mulData), .addData(addData),
    .fetchSel(fetchSel), .mulSel(mulSel), .addSel(addSel),
    .busValid(busValid), .busTag(busTag), .busData(busData)
  );

  always #4 clk = ~clk;  // 125 MHz

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // request patterns: bits 5:0 fetch, 7:6 mul/div, 10:8 add (ascending tag order)
  localparam logic [10:0] VEC [8] = '{
    11'h001, 11'h400, 11'h7FF, 11'h0C0,
    11'h555, 11'h2AA, 11'h13F, 11'h700
  };

  function automatic logic [3:0] tagOf(input int b);
    return (b < 6) ? 4'(b + 1) : 4'(b + 2);
  endfunction

  function automatic logic [DW-1:0] dataOf(input logic [3:0] t);
    return 16'h8000 | (16'(t) * 16'h0111);
  endfunction

  // n-th (0-based) highest set bit index, -1 if none
  function automatic int nthHigh(input logic [10:0] m, input int n);
    int seen = 0;
    for (int b = 10; b >= 0; b--) begin
      if (m[b]) begin
        if (seen == n) return b;
        seen++;
      end
    end
    return -1;
  endfunction

  logic [10:0] pending = '0;
  logic [10:0] lastSel = '0;
  logic sV;
  logic [3:0] sT;
  logic [DW-1:0] sD;
  logic [10:0] sSel;

  task automatic report(input logic ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one cycle: sample outputs mid-cycle, then update the producer model and drive
  task automatic step(input logic [10:0] addMask);
    @(negedge clk);
    sV = busValid; sT = busTag; sD = busData;
    sSel = {addSel, mulSel, fetchSel};
    pending = pending & ~lastSel;  // drop one cycle after select
    lastSel = sSel;
    pending = pending | addMask;
    {addReq, mulReq, fetchReq} = pending;
  endtask

  // expect bit index b (or idle when b < 0) on the sampled outputs
  task automatic expectSlot(input int b, input string req);
    logic [3:0] et;
    logic [10:0] es;
    logic [DW-1:0] ed;
    et = (b < 0) ? 4'd0 : tagOf(b);
    es = (b < 0) ? 11'd0 : (11'd1 << b);
    ed = (b < 0) ? '0 : dataOf(et);
    report(sV == (b >= 0) && sT == et, req, "valid/tag", {27'd0, sV, sT}, {27'd0, (b >= 0), et});
    report(sD == ed, req, "data", 32'(sD), 32'(ed));
    report(sSel == es, "R7", "select", 32'(sSel), 32'(es));
  endtask

  initial begin
    for (int i = 0; i < 6; i++) fetchData[i*DW +: DW] = dataOf(4'(i + 1));
    for (int j = 0; j < 2; j++) mulData[j*DW +: DW] = dataOf(4'(j + 8));
    for (int k = 0; k < 3; k++) addData[k*DW +: DW] = dataOf(4'(k + 10));

    // reset state (R6, R8)
    step('0); step('0);
    expectSlot(-1, "R8");
    @(negedge clk); rst = 1'b0;

    // table walk: R1, R2, R3, R4, R5
    for (int v = 0; v < 8; v++) begin
      int cnt;
      cnt = $countones(VEC[v]);
      step(VEC[v]);
      for (int r = 1; r <= cnt + 3; r++) begin
        step('0);
        if (r >= 2 && r - 2 < cnt) expectSlot(nthHigh(VEC[v], r - 2), "R3");
        else expectSlot(-1, "R4");
      end
      step('0); step('0);
    end

    // late higher-tag arrival overtakes queued lower tags (R9)
    step(11'h006);                 // tags 3 and 2
    step(11'h400); expectSlot(-1, "R2");  // tag 12 one cycle later
    step('0); expectSlot(2, "R9");
    step('0); expectSlot(10, "R9");
    step('0); expectSlot(1, "R9");
    step('0); expectSlot(-1, "R5");
    step('0); expectSlot(-1, "R5");
    step('0); step('0);

    // reset flushes a request in flight (R8)
    step(11'h010);                 // tag 5
    @(negedge clk);
    pending = '0; lastSel = '0; {addReq, mulReq, fetchReq} = '0; rst = 1'b1;
    step('0); expectSlot(-1, "R8");
    rst = 1'b0;
    step('0); expectSlot(-1, "R8");
    step('0); expectSlot(-1, "R8");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule